// File: doc/BRIEF.md
# Streaming Radix-2 FFT Engine

The block turns a stream of complex time-domain samples into a stream of complex spectrum bins, one fixed-length transform of N points at a time. Samples come in on a data word that is marked valid by a strobe. After every N accepted samples the engine computes a decimation-in-time transform. The stage addressing used here leaves the bins in natural order, with no reorder pass. Results are then played out on an output word with its own strobe.

Storage is five N-entry complex buffers. Two capture buffers swap roles: one fills while the other feeds the first stage. Two working buffers trade data back and forth between stages. A dedicated result buffer receives the last stage and is read out. A single complex butterfly runs once per clock, and its twiddle factors come from a constant table that is computed when the design is elaborated. Each stage halves its results, so the output is the DFT divided by N. If a block of input completes while the previous transform is still being computed or played out, the new block is dropped and a sticky flag is raised.

Top module: `fft_stream`

## Requirements
- R1: While reset is held and directly after it, `bin_valid` and `ovf_flag` are 0 and `bin_data` is all zeros.
- R2: The bins of every transform equal X[k]/N, with X[k] = sum over n of x[n]·e^(−j2πkn/N). Each real and imaginary part must be within ±6 LSB, and the bins are emitted in order k = 0 … N−1. Samples and bins are packed with the real part in bits [2W−1:W] and the imaginary part in bits [W−1:0], both two's complement.
- R3: Each transform's bins leave as one burst of exactly N consecutive cycles with `bin_valid` high.
- R4: The first cycle of a burst comes L·N/2+1 clock edges after the edge that captures the N-th sample of its block, where L = log2(N).
- R5: Samples can keep arriving while an earlier transform is computed and played out. A block whose last sample is captured at least L·N/2+N+1 edges after the previous accepted block is transformed correctly, and it does not raise `ovf_flag`.
- R6: If a block completes while the engine is still busy, `ovf_flag` rises and that block produces no output. The burst of the transform already in progress is unaffected.
- R7: Once set, `ovf_flag` stays 1 until reset, even while later blocks are processed normally. Reset clears it.
- R8: `bin_data` is all zeros in every cycle in which `bin_valid` is 0.
- R9: A value on `smp_data` in a cycle where `smp_valid` is 0 is not stored and has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | 2*W | Complex input sample {real, imag} |
| smp_valid | input | 1 | Marks `smp_data` as a new sample |
| bin_data | output | 2*W | Complex spectrum bin {real, imag} |
| bin_valid | output | 1 | Marks `bin_data` as a valid bin |
| ovf_flag | output | 1 | Sticky flag: an input block arrived while the engine was busy |

## Verification
An impulse is placed at every one of the N positions. Each one should give a flat magnitude whose phase rotates with the position, which exposes wrong read addresses and swapped twiddle signs. A complex tone is then placed on every bin. Each tone must land on its own bin alone, which exposes wrong bin ordering and wrong stage ordering. Blocks of pseudo-random samples mix all paths together. Junk is driven on the data input between strobes to show that it is ignored. A final back-to-back burst of blocks, followed by one spaced block and then a reset, separates the drop behaviour from the sticky flag and from its clearing.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_OUT  = 2'd2
  } fft_state_e;

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic [$clog2(N)-2:0] idx,
  output logic signed [W-1:0]  tw_re,
  output logic signed [W-1:0]  tw_im
);

  localparam int     HALF = N / 2;
  localparam int     SH   = 30 - (W - 2);
  localparam longint PI_Q = 64'sd3373259426;  // pi in Q30

  // cos or sin of 2*pi*k/N in Q30, integer Taylor series on a reduced angle
  function automatic longint trig_q30(input int k, input bit want_sin);
    longint th, x2, term, acc;
    bit     flip;
    th   = (PI_Q * 2 * longint'(k)) / longint'(N);
    flip = 1'b0;
    if (th > PI_Q / 2) begin
      th   = PI_Q - th;
      flip = 1'b1;
    end
    x2   = (th * th) >>> 30;
    term = want_sin ? th : (64'sd1 <<< 30);
    acc  = term;
    for (int i = 1; i < 12; i++) begin
      term = -((term * x2) >>> 30);
      if (want_sin) term = term / longint'((2 * i) * (2 * i + 1));
      else          term = term / longint'((2 * i - 1) * (2 * i));
      acc = acc + term;
    end
    if (flip && !want_sin) acc = -acc;
    return acc;
  endfunction

  function automatic longint to_fixed(input longint q30);
    return (q30 + (64'sd1 <<< (SH - 1))) >>> SH;
  endfunction

  logic signed [W-1:0] rom_re [HALF];
  logic signed [W-1:0] rom_im [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_rom
    localparam longint CV = to_fixed(trig_q30(k, 1'b0));
    localparam longint SV = to_fixed(trig_q30(k, 1'b1));
    assign rom_re[k] = W'(CV);
    assign rom_im[k] = W'(-SV);
  end

  assign tw_re = rom_re[idx];
  assign tw_im = rom_im[idx];

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter int N = 16
) (
  input  logic [$clog2($clog2(N)+1)-1:0] stage,
  input  logic [$clog2(N)-2:0]           bfly,
  output logic [$clog2(N)-1:0]           rd_a,
  output logic [$clog2(N)-1:0]           rd_b,
  output logic [$clog2(N)-1:0]           wr_a,
  output logic [$clog2(N)-1:0]           wr_b,
  output logic [$clog2(N)-2:0]           tw_idx
);

  localparam int LG = $clog2(N);
  localparam int BW = LG - 1;

  // Stage s (0-based) uses span 2^(LG-1-s): butterfly i splits into
  // a low part j below the span and a high part ks at or above it.
  always_comb begin
    int            lgs;
    logic [LG-1:0] msk, iw, jv, ks, span;
    lgs    = LG - 1 - int'(stage);
    span   = LG'(1) << lgs;
    msk    = span - LG'(1);
    iw     = LG'(bfly);
    jv     = iw & msk;
    ks     = iw & ~msk;
    rd_a   = (ks << 1) | jv;
    rd_b   = ((ks << 1) | jv) + span;
    wr_a   = iw;
    wr_b   = iw | LG'(N / 2);
    tw_idx = BW'(ks);
  end

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  input  logic signed [W-1:0] t_re,
  input  logic signed [W-1:0] t_im,
  output logic signed [W-1:0] p_re,
  output logic signed [W-1:0] p_im,
  output logic signed [W-1:0] m_re,
  output logic signed [W-1:0] m_im
);

  localparam int PW = 2 * W + 2;
  localparam int SH = W - 2;   // twiddles carry W-2 fraction bits

  function automatic logic signed [PW-1:0] rot_re(
    input logic signed [W-1:0] xr, input logic signed [W-1:0] xi,
    input logic signed [W-1:0] cr, input logic signed [W-1:0] ci);
    logic signed [PW-1:0] acc;
    acc = PW'(xr) * PW'(cr) - PW'(xi) * PW'(ci);
    return acc >>> SH;
  endfunction

  function automatic logic signed [PW-1:0] rot_im(
    input logic signed [W-1:0] xr, input logic signed [W-1:0] xi,
    input logic signed [W-1:0] cr, input logic signed [W-1:0] ci);
    logic signed [PW-1:0] acc;
    acc = PW'(xr) * PW'(ci) + PW'(xi) * PW'(cr);
    return acc >>> SH;
  endfunction

  function automatic logic signed [W-1:0] halve(input logic signed [PW-1:0] v);
    return W'(v >>> 1);
  endfunction

  logic signed [PW-1:0] tb_re, tb_im, ax_re, ax_im;

  always_comb begin
    tb_re = rot_re(b_re, b_im, t_re, t_im);
    tb_im = rot_im(b_re, b_im, t_re, t_im);
    ax_re = PW'(a_re);
    ax_im = PW'(a_im);
    p_re  = halve(ax_re + tb_re);
    p_im  = halve(ax_im + tb_im);
    m_re  = halve(ax_re - tb_re);
    m_im  = halve(ax_im - tb_im);
  end

endmodule

// File: rtl/fft_stream.sv
module fft_stream
  import fft_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] smp_data,
  input  logic           smp_valid,
  output logic [2*W-1:0] bin_data,
  output logic           bin_valid,
  output logic           ovf_flag
);

  localparam int CW = 2 * W;
  localparam int LG = $clog2(N);
  localparam int BW = LG - 1;
  localparam int SW = $clog2(LG + 1);
  localparam logic [SW-1:0] LAST_STG  = SW'(LG - 1);
  localparam logic [BW-1:0] LAST_BFLY = BW'(N / 2 - 1);
  localparam logic [LG-1:0] LAST_IDX  = LG'(N - 1);

  // buffers: two capture, two working, one result
  logic [CW-1:0] cap_mem [2][N];
  logic [CW-1:0] wrk_mem [2][N];
  logic [CW-1:0] res_mem [N];

  fft_state_e    state;
  logic [SW-1:0] stage;
  logic [BW-1:0] bfly;
  logic [LG-1:0] wr_cnt, rd_cnt;
  logic          wr_sel, rd_sel;

  // named events for the checker
  logic blk_full, eng_busy, start_xfm;
  assign blk_full  = smp_valid && (wr_cnt == LAST_IDX);
  assign eng_busy  = (state != ST_IDLE);
  assign start_xfm = blk_full && !eng_busy;

  logic [LG-1:0] rd_a, rd_b, wr_a, wr_b;
  logic [BW-1:0] tw_idx;

  fft_addr_gen #(.N(N)) u_addr (
    .stage (stage),
    .bfly  (bfly),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .wr_a  (wr_a),
    .wr_b  (wr_b),
    .tw_idx(tw_idx)
  );

  logic signed [W-1:0] tw_re, tw_im;

  fft_twiddle_rom #(.N(N), .W(W)) u_rom (
    .idx  (tw_idx),
    .tw_re(tw_re),
    .tw_im(tw_im)
  );

  logic [CW-1:0] op_a, op_b;
  always_comb begin
    if (stage == '0) begin
      op_a = cap_mem[rd_sel][rd_a];
      op_b = cap_mem[rd_sel][rd_b];
    end else begin
      op_a = wrk_mem[~stage[0]][rd_a];
      op_b = wrk_mem[~stage[0]][rd_b];
    end
  end

  logic signed [W-1:0] p_re, p_im, m_re, m_im;

  fft_butterfly #(.W(W)) u_bfly (
    .a_re(op_a[CW-1:W]),
    .a_im(op_a[W-1:0]),
    .b_re(op_b[CW-1:W]),
    .b_im(op_b[W-1:0]),
    .t_re(tw_re),
    .t_im(tw_im),
    .p_re(p_re),
    .p_im(p_im),
    .m_re(m_re),
    .m_im(m_im)
  );

  // storage writes (no reset on memories)
  always_ff @(posedge clk) begin
    if (smp_valid) cap_mem[wr_sel][wr_cnt] <= smp_data;
    if (state == ST_CALC) begin
      if (stage == LAST_STG) begin
        res_mem[wr_a] <= {p_re, p_im};
        res_mem[wr_b] <= {m_re, m_im};
      end else begin
        wrk_mem[stage[0]][wr_a] <= {p_re, p_im};
        wrk_mem[stage[0]][wr_b] <= {m_re, m_im};
      end
    end
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stage     <= '0;
      bfly      <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      wr_sel    <= 1'b0;
      rd_sel    <= 1'b0;
      ovf_flag  <= 1'b0;
      bin_valid <= 1'b0;
      bin_data  <= '0;
    end else begin
      if (smp_valid) wr_cnt <= wr_cnt + LG'(1);
      if (blk_full && eng_busy) ovf_flag <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (start_xfm) begin
            wr_sel <= ~wr_sel;
            rd_sel <= wr_sel;
            stage  <= '0;
            bfly   <= '0;
            state  <= ST_CALC;
          end
        end
        ST_CALC: begin
          bfly <= bfly + BW'(1);
          if (bfly == LAST_BFLY) begin
            bfly <= '0;
            if (stage == LAST_STG) begin
              rd_cnt <= '0;
              state  <= ST_OUT;
            end else begin
              stage <= stage + SW'(1);
            end
          end
        end
        ST_OUT: begin
          rd_cnt <= rd_cnt + LG'(1);
          if (rd_cnt == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase

      bin_valid <= (state == ST_OUT);
      bin_data  <= (state == ST_OUT) ? res_mem[rd_cnt] : '0;
    end
  end

endmodule

// File: rtl/fft_stream_chk.sv
module fft_stream_chk #(
  parameter int N = 16,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [2*W-1:0] bin_data,
  input logic           bin_valid,
  input logic           ovf_flag,
  input logic           blk_full,
  input logic           eng_busy,
  input logic           start_xfm
);

  localparam int LG      = $clog2(N);
  localparam int LAT_CHK = LG * N / 2 + 2;

  int run_cnt;
  int lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= 0;
      lat_cnt <= 0;
    end else begin
      run_cnt <= bin_valid ? run_cnt + 1 : 0;
      if (start_xfm)              lat_cnt <= 1;
      else if (lat_cnt != 0 && lat_cnt < 1000000) lat_cnt <= lat_cnt + 1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);  // R7

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(blk_full && eng_busy));  // R6

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    !bin_valid |-> (bin_data == '0));  // R8

  AST_BURST_MAX: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> (run_cnt < N));  // R3

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(bin_valid) |-> (run_cnt == N));  // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(bin_valid) |-> (lat_cnt == LAT_CHK));  // R4

endmodule

bind fft_stream fft_stream_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bin_data (bin_data),
  .bin_valid(bin_valid),
  .ovf_flag (ovf_flag),
  .blk_full (blk_full),
  .eng_busy (eng_busy),
  .start_xfm(start_xfm)
);

// File: tb/tb_fft_stream.sv
`timescale 1ns/1ps
module tb_fft_stream;

  localparam int    N   = 16;
  localparam int    W   = 16;
  localparam int    LG  = 4;
  localparam int    NB  = 48;
  localparam int    TOL = 6;
  localparam int    LAT = LG * N / 2 + 1;
  localparam real   TWO_PI = 6.283185307179586;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2*W-1:0] smp_data = '0;
  logic           smp_valid = 1'b0;
  logic [2*W-1:0] bin_data;
  logic           bin_valid;
  logic           ovf_flag;

  always #2 clk = ~clk;  // 250 MHz

  fft_stream #(.N(N), .W(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .smp_data (smp_data),
    .smp_valid(smp_valid),
    .bin_data (bin_data),
    .bin_valid(bin_valid),
    .ovf_flag (ovf_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int in_re  [NB][N];
  int in_im  [NB][N];
  int out_re [NB][N];
  int out_im [NB][N];
  int fill_cyc  [NB];
  int first_cyc [NB];
  int last_cyc  [NB];
  int cyc  = 0;
  int sent = 0;
  int got  = 0;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && smp_valid) begin
      sent <= sent + 1;
      if (sent % N == N - 1) fill_cyc[sent / N] <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && bin_valid) begin
      int slot, idx;
      slot = got / N;
      idx  = got % N;
      if (slot < NB) begin
        out_re[slot][idx] = int'($signed(bin_data[2*W-1:W]));
        out_im[slot][idx] = int'($signed(bin_data[W-1:0]));
        if (idx == 0)     first_cyc[slot] = cyc;
        if (idx == N - 1) last_cyc[slot]  = cyc;
      end
      got = got + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 4001) - 2000;
  endfunction

  task automatic send_block(input int b, input int gap);
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = {W'(in_re[b][n]), W'(in_im[b][n])};
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = {W'(n * 1237 + g * 311), W'(-n * 913 - g)};  // junk, R9
      end
    end
  endtask

  task automatic wait_out(input int target, input int limit);
    for (int c = 0; c < limit && got < target; c++) @(negedge clk);
  endtask

  // compare one delivered transform against a reference DFT / N
  task automatic verify(input int slot, input int b, input string req);
    for (int k = 0; k < N; k++) begin
      real sr, si, ang;
      int  er, ei;
      bit  ok;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        ang = -TWO_PI * real'(k * n) / real'(N);
        sr += real'(in_re[b][n]) * $cos(ang) - real'(in_im[b][n]) * $sin(ang);
        si += real'(in_re[b][n]) * $sin(ang) + real'(in_im[b][n]) * $cos(ang);
      end
      er = int'(sr / real'(N));
      ei = int'(si / real'(N));
      ok = (out_re[slot][k] - er <= TOL) && (er - out_re[slot][k] <= TOL) &&
           (out_im[slot][k] - ei <= TOL) && (ei - out_im[slot][k] <= TOL);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s block %0d bin %0d: actual (%0d,%0d) expected (%0d,%0d)",
                 req, b, k, out_re[slot][k], out_im[slot][k], er, ei);
      end
    end
    check(first_cyc[slot] - fill_cyc[b] == LAT, "R4", "latency",
          first_cyc[slot] - fill_cyc[b], LAT);
    check(last_cyc[slot] - first_cyc[slot] == N - 1, "R3", "burst span",
          last_cyc[slot] - first_cyc[slot], N - 1);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // stimulus tables
    for (int b = 0; b < N; b++)
      for (int n = 0; n < N; n++) begin
        in_re[b][n] = (n == b) ? 3000 : 0;
        in_im[b][n] = (n == b) ? -1500 : 0;
      end
    for (int t = 0; t < N; t++)
      for (int n = 0; n < N; n++) begin
        in_re[N + t][n] = int'(2000.0 * $cos(TWO_PI * real'(t * n) / real'(N)));
        in_im[N + t][n] = int'(2000.0 * $sin(TWO_PI * real'(t * n) / real'(N)));
      end
    for (int b = 2 * N; b < NB; b++)
      for (int n = 0; n < N; n++) begin
        in_re[b][n] = next_rand();
        in_im[b][n] = next_rand();
      end

    // R1: reset state
    repeat (4) @(negedge clk);
    check(bin_valid == 1'b0, "R1", "bin_valid in reset", int'(bin_valid), 0);
    check(ovf_flag == 1'b0, "R1", "ovf_flag in reset", int'(ovf_flag), 0);
    check(bin_data == '0, "R1", "bin_data in reset", int'(bin_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check(bin_valid == 1'b0 && bin_data == '0, "R1", "output after reset",
          int'(bin_valid), 0);

    // R2 R5 R9: impulses, tones, random blocks, spaced 64 cycles apart
    for (int b = 0; b < 40; b++) send_block(b, 4);
    @(negedge clk);
    smp_valid = 1'b0;
    wait_out(40 * N, 400);
    check(got == 40 * N, "R5", "bins delivered", got, 40 * N);
    check(ovf_flag == 1'b0, "R5", "no overflow at spaced rate", int'(ovf_flag), 0);
    for (int b = 0; b < 40; b++) verify(b, b, b < 32 ? "R2" : "R5");

    // R6: three blocks back to back, only the first is transformed
    for (int b = 40; b < 43; b++) send_block(b, 1);
    @(negedge clk);
    smp_valid = 1'b0;
    wait_out(42 * N, 200);
    check(ovf_flag == 1'b1, "R6", "overflow on busy fill", int'(ovf_flag), 1);
    check(got == 41 * N, "R6", "dropped blocks give no bins", got, 41 * N);
    verify(40, 40, "R6");

    // R7: flag stays up while a later spaced block is processed
    repeat (60) @(negedge clk);
    send_block(43, 4);
    @(negedge clk);
    smp_valid = 1'b0;
    wait_out(42 * N, 200);
    check(got == 42 * N, "R7", "later block delivered", got, 42 * N);
    check(ovf_flag == 1'b1, "R7", "overflow held", int'(ovf_flag), 1);
    verify(41, 43, "R7");

    // R7: reset clears the flag
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ovf_flag == 1'b0, "R7", "overflow cleared by reset", int'(ovf_flag), 0);
    check(bin_valid == 1'b0, "R1", "bin_valid after second reset", int'(bin_valid), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule